// File: doc/BRIEF.md
# Timer Compare-Match Status Flags

This block holds two timer channels, each split into three sub-channels (A, B, C). Every sub-channel has a free-running 16-bit counter and a programmable cycle register. It also has one sticky status flag that records a compare event. Software starts and stops each channel through a control register. Software also chooses, per channel, between two counting modes. In ordinary mode the counter counts up and wraps to zero on a match with the cycle register. In complementary PWM mode the counter rises to the cycle value, falls back to zero, and repeats.

The event that sets a flag depends on the mode. In ordinary mode it is the counter matching the cycle register. In complementary mode it is the counter sitting at zero while it counts down. A flag stays set until software clears it with a two-step handshake: it must first read the flag as 1, and then write a 0 to that bit. Only channels marked capable by a parameter can enter complementary mode. By default that is channel 0 alone. On a channel that is not capable, the mode bit is stored but has no effect.

All registers sit behind a single-cycle strobe bus with a 5-bit word address and 16-bit data. Reads are combinational during the strobe.

Top module: `tmr_cmf_status`

## Requirements
- R1: After reset, both status registers, the control register and every counter read 0, and every cycle register reads 0xFFFF.
- R2: Status register for channel c is at address c (0x00, 0x01). Bit 0 is sub-channel A, bit 1 is B and bit 2 is C. Bits 15..3 read as 0.
- R3: In ordinary mode a running counter counts up by one per cycle and wraps to 0 on the cycle after it equals its cycle register. The flag reads 1 from that same cycle on.
- R4: In complementary mode a running counter counts up to its cycle register and then down to 0, repeating with a period of twice the cycle value. A match at the top does not set the flag. The flag reads 1 from the cycle after the counter is 0 while counting down.
- R5: A flag clears only when a read of its status register has returned it as 1 and a later write puts 0 in its bit. After that, the flag reads 0.
- R6: Writing 0 to a flag that has not been read as 1 leaves it at 1.
- R7: Writing 1 to a flag bit leaves the flag unchanged and does not cancel an earlier read of it as 1.
- R8: When a set event and a valid clear write land on the same clock edge, the flag stays 1.
- R9: Control register at 0x02: bit c starts channel c, and bit 2+c selects complementary mode for channel c. On a channel not marked capable (channel 1 by default), the mode bit reads back but the channel counts and flags in ordinary mode.
- R10: Cycle registers are read/write at 0x10 + 4·c + s, and counters are read-only at 0x18 + 4·c + s (s = 0,1,2 for A,B,C). A stopped channel holds its counters at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Single-cycle access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, valid with bus_sel |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_sel is high with bus_wr low; 0 otherwise |

## Verification
The embedded properties watch every cycle for several rules. A set event always leaves its flag at 1, so set beats clear. A flag that is not armed, or that receives a write of 1, never falls. A flag only falls after it has been armed, and it is armed only by a read that returned it as 1. The properties also check that a stopped counter returns to zero, that an ordinary-mode match wraps the counter, that a descending counter steps down by exactly one, and that the unused status bits stay zero. The bench scenarios are needed for the rest: the exact cycle on which a flag first becomes visible in each mode, and the absence of a flag at the top of a complementary ramp. They also cover the full counting sequences for several cycle values (including zero) and a capable mode bit being ignored on channel 1. Finally, they show the whole read-then-write-zero handshake seen only at the bus.

// File: rtl/tmr_cmf_pkg.sv
package tmr_cmf_pkg;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } cnt_dir_e;

   // Word address map (behaviour depends on these bases)
   localparam int STAT_BASE = 0;
   localparam int CTRL_ADDR = 2;
   localparam int CYC_BASE  = 16;
   localparam int CNT_BASE  = 24;
   localparam int SUB_STRIDE_LOG2 = 2;

   function automatic int reg_index(input int ch, input int sub);
      return (ch << SUB_STRIDE_LOG2) + sub;
   endfunction

endpackage

// File: rtl/tmr_subcnt.sv
module tmr_subcnt
   import tmr_cmf_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             comp,
   input  logic             cyc_we,
   input  logic [CNT_W-1:0] cyc_wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cyc,
   output logic             hit
);

   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d, cyc_q;
   cnt_dir_e         dir_q, dir_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cyc_q <= '1;
      else if (cyc_we) cyc_q <= cyc_wdata;
   end

   always_comb begin
      cnt_d = cnt_q;
      dir_d = dir_q;
      if (!run) begin
         cnt_d = ZERO;
         dir_d = DIR_UP;
      end else if (!comp) begin
         cnt_d = (cnt_q == cyc_q) ? ZERO : cnt_q + ONE;
         dir_d = DIR_UP;
      end else if (dir_q == DIR_UP) begin
         if (cnt_q >= cyc_q) begin
            dir_d = DIR_DOWN;
            cnt_d = (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
         end else begin
            cnt_d = cnt_q + ONE;
         end
      end else begin
         if (cnt_q == ZERO) begin
            dir_d = DIR_UP;
            cnt_d = (cyc_q == ZERO) ? ZERO : ONE;
         end else begin
            cnt_d = cnt_q - ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
         dir_q <= DIR_UP;
      end else begin
         cnt_q <= cnt_d;
         dir_q <= dir_d;
      end
   end

   assign hit = run && (comp ? (dir_q == DIR_DOWN && cnt_q == ZERO)
                             : (cnt_q == cyc_q));
   assign cnt = cnt_q;
   assign cyc = cyc_q;

   // R10: a stopped counter sits at zero on the next cycle
   p_stop_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt_q == ZERO);

   // R3: ordinary-mode match wraps the counter
   p_ord_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !comp && cnt_q == cyc_q) |=> cnt_q == ZERO);

   // R4: the falling ramp steps by exactly one
   p_comp_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && comp && dir_q == DIR_DOWN && cnt_q != ZERO)
      |=> cnt_q == $past(cnt_q) - ONE);

endmodule

// File: rtl/tmr_cmf_cell.sv
module tmr_cmf_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic rd_hit,
   input  logic wr_hit,
   input  logic wbit,
   output logic flag
);

   logic flag_q, armed_q;
   logic clr_ok;

   assign clr_ok = wr_hit && !wbit && armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (set_ev)      flag_q <= 1'b1;
         else if (clr_ok) flag_q <= 1'b0;

         if (clr_ok)                armed_q <= 1'b0;
         else if (rd_hit && flag_q) armed_q <= 1'b1;
      end
   end

   assign flag = flag_q;

   // R8: a set event always leaves the flag at 1
   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev |=> flag_q);

   // R6: an unarmed flag cannot fall
   p_unarmed_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !armed_q) |=> flag_q);

   // R7: writing 1 never drops the flag
   p_write_one_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && wr_hit && wbit) |=> flag_q);

   // R5: a fall is always preceded by arming
   p_fall_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(armed_q));

   // R5: arming only comes from a read that returned 1
   p_arm_from_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed_q) |-> $past(rd_hit && flag_q));

endmodule

// File: rtl/tmr_cmf_status.sv
module tmr_cmf_status
   import tmr_cmf_pkg::*;
#(
   parameter int           N_CH         = 2,
   parameter int           N_SUB        = 3,
   parameter int           CNT_W        = 16,
   parameter int           DATA_W       = 16,
   parameter int           ADDR_W       = 5,
   parameter logic [1:0]   COMP_CAPABLE = 2'b01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam int CTRL_W = 2 * N_CH;

   if (N_CH < 1 || N_CH > 2)     begin : g_bad_ch   $error("N_CH must be 1 or 2");        end
   if (N_SUB < 1 || N_SUB > 4)   begin : g_bad_sub  $error("N_SUB must be 1..4");         end
   if (CNT_W > DATA_W)           begin : g_bad_cnt  $error("CNT_W exceeds DATA_W");       end
   if (CTRL_W > DATA_W)          begin : g_bad_ctrl $error("control field too wide");     end
   if (N_SUB >= DATA_W)          begin : g_bad_stat $error("status field too wide");      end
   if (ADDR_W < 5)               begin : g_bad_addr $error("ADDR_W must be at least 5");  end

   logic                         rd_req, wr_req;
   logic [CTRL_W-1:0]            ctrl_q;
   logic [N_CH-1:0]              comp_eff;
   logic [N_CH-1:0][N_SUB-1:0]   flag_vec;
   logic [N_CH-1:0][N_SUB-1:0]   hit_vec;
   logic [CNT_W-1:0]             cnt_a [N_CH][N_SUB];
   logic [CNT_W-1:0]             cyc_a [N_CH][N_SUB];

   assign rd_req = bus_sel && !bus_wr;
   assign wr_req = bus_sel &&  bus_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (wr_req && bus_addr == ADDR_W'(CTRL_ADDR))
         ctrl_q <= bus_wdata[CTRL_W-1:0];
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic stat_rd, stat_wr;
      assign stat_rd = rd_req && bus_addr == ADDR_W'(STAT_BASE + c);
      assign stat_wr = wr_req && bus_addr == ADDR_W'(STAT_BASE + c);

      if (COMP_CAPABLE[c]) begin : g_updown
         assign comp_eff[c] = ctrl_q[N_CH + c];
      end else begin : g_uponly
         assign comp_eff[c] = 1'b0;
      end

      for (genvar s = 0; s < N_SUB; s++) begin : g_sub
         logic cyc_we;
         assign cyc_we = wr_req && bus_addr == ADDR_W'(CYC_BASE + reg_index(c, s));

         tmr_subcnt #(.CNT_W(CNT_W)) i_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (ctrl_q[c]),
            .comp      (comp_eff[c]),
            .cyc_we    (cyc_we),
            .cyc_wdata (bus_wdata[CNT_W-1:0]),
            .cnt       (cnt_a[c][s]),
            .cyc       (cyc_a[c][s]),
            .hit       (hit_vec[c][s])
         );

         tmr_cmf_cell i_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_ev (hit_vec[c][s]),
            .rd_hit (stat_rd),
            .wr_hit (stat_wr),
            .wbit   (bus_wdata[s]),
            .flag   (flag_vec[c][s])
         );
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_req) begin
         if (bus_addr == ADDR_W'(CTRL_ADDR))
            bus_rdata = DATA_W'(ctrl_q);
         for (int c = 0; c < N_CH; c++) begin
            if (bus_addr == ADDR_W'(STAT_BASE + c))
               bus_rdata = DATA_W'(flag_vec[c]);
            for (int s = 0; s < N_SUB; s++) begin
               if (bus_addr == ADDR_W'(CYC_BASE + reg_index(c, s)))
                  bus_rdata = DATA_W'(cyc_a[c][s]);
               if (bus_addr == ADDR_W'(CNT_BASE + reg_index(c, s)))
                  bus_rdata = DATA_W'(cnt_a[c][s]);
            end
         end
      end
   end

   // R2: unused status bits stay zero on every status read
   p_stat_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && bus_addr < ADDR_W'(STAT_BASE + N_CH))
      |-> bus_rdata[DATA_W-1:N_SUB] == '0);

endmodule

// File: tb/test_tmr_cmf_status.sv
`timescale 1ns/1ps
module test_tmr_cmf_status;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   tmr_cmf_status i_tmr_cmf_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   // {ch[43], sub[42:41], comp[40], cyc[39:24], edges[23:16], exp_cnt[15:0]}
   localparam int NV = 10;
   localparam logic [43:0] TBL [NV] = '{
      {1'b0, 2'd0, 1'b0, 16'd3, 8'd1, 16'd1},  // R3 ordinary rising
      {1'b0, 2'd0, 1'b0, 16'd3, 8'd4, 16'd0},  // R3 wrap after match
      {1'b0, 2'd1, 1'b0, 16'd5, 8'd8, 16'd2},  // R3 second period
      {1'b0, 2'd2, 1'b1, 16'd3, 8'd3, 16'd3},  // R4 top of ramp
      {1'b0, 2'd2, 1'b1, 16'd3, 8'd4, 16'd2},  // R4 turning down
      {1'b0, 2'd0, 1'b1, 16'd4, 8'd8, 16'd0},  // R4 bottom
      {1'b0, 2'd1, 1'b1, 16'd4, 8'd9, 16'd1},  // R4 rising again
      {1'b1, 2'd0, 1'b1, 16'd3, 8'd5, 16'd1},  // R9 mode bit ignored
      {1'b1, 2'd2, 1'b0, 16'd2, 8'd7, 16'd1},  // R3 channel 1
      {1'b0, 2'd2, 1'b1, 16'd0, 8'd3, 16'd0}   // R4 zero cycle value
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      logic [15:0] d;
      @(negedge clk);
      do_reset();

      // R1 reset state
      rd(5'h00, d); check("R1 status ch0", d, 16'h0000);
      rd(5'h01, d); check("R1 status ch1", d, 16'h0000);
      rd(5'h02, d); check("R1 control", d, 16'h0000);
      rd(5'h18, d); check("R1 counter ch0 A", d, 16'h0000);
      rd(5'h16, d); check("R1 cycle ch1 C", d, 16'hFFFF);

      // Table of counting sequences (R3, R4, R9)
      for (int i = 0; i < NV; i++) begin
         logic [43:0] v;
         logic [4:0]  idx;
         logic [15:0] ctl;
         v   = TBL[i];
         idx = {1'b0, v[43], v[42:41]};
         ctl = 16'(1) << v[43];
         if (v[40]) ctl = ctl | (16'(4) << v[43]);
         wr(5'h02, 16'h0000);
         wr(5'h10 | idx, v[39:24]);
         wr(5'h02, ctl);
         repeat (int'(v[23:16])) @(negedge clk);
         rd(5'h18 | idx, d);
         check(v[43] ? "R9 table count" : (v[40] ? "R4 table count" : "R3 table count"),
               d, v[15:0]);
      end

      // R3 flag timing, R5 clear handshake
      do_reset();
      wr(5'h11, 16'd2);
      wr(5'h02, 16'h0001);
      repeat (2) @(negedge clk);
      rd(5'h00, d); check("R3 flag not yet set on match cycle", d, 16'h0000);
      rd(5'h00, d); check("R3 flag B set after match", d, 16'h0002);
      wr(5'h02, 16'h0000);
      wr(5'h00, 16'h0000);
      rd(5'h00, d); check("R5 cleared after read-1 then write-0", d, 16'h0000);

      // R6 unarmed write, R7 write of one
      wr(5'h02, 16'h0001);
      repeat (3) @(negedge clk);
      wr(5'h02, 16'h0000);
      wr(5'h00, 16'h0000);
      rd(5'h00, d); check("R6 write 0 without read keeps flag", d, 16'h0002);
      wr(5'h00, 16'hFFFF);
      rd(5'h00, d); check("R7 write 1 keeps flag", d, 16'h0002);
      wr(5'h00, 16'h0000);
      rd(5'h00, d); check("R5 clear after read survives a write of 1", d, 16'h0000);

      // R8 set beats clear on the same edge
      do_reset();
      wr(5'h11, 16'd2);
      wr(5'h02, 16'h0001);
      repeat (3) @(negedge clk);
      rd(5'h00, d); check("R8 setup flag set", d, 16'h0002);
      @(negedge clk);
      wr(5'h00, 16'h0000);
      wr(5'h02, 16'h0000);
      rd(5'h00, d); check("R8 set wins over clear", d, 16'h0002);

      // R4 complementary flag timing
      do_reset();
      wr(5'h10, 16'd3);
      wr(5'h02, 16'h0005);
      repeat (4) @(negedge clk);
      rd(5'h00, d); check("R4 no flag at top match", d, 16'h0000);
      repeat (2) @(negedge clk);
      rd(5'h00, d); check("R4 flag after zero while falling", d, 16'h0001);

      // R2 bit layout for sub-channel C of channel 1
      do_reset();
      wr(5'h16, 16'd1);
      wr(5'h02, 16'h0002);
      repeat (2) @(negedge clk);
      rd(5'h01, d); check("R2 channel 1 bit 2 is C", d, 16'h0004);
      rd(5'h00, d); check("R2 channel 0 untouched", d, 16'h0000);

      // R9 mode bit ignored on channel 1
      do_reset();
      wr(5'h14, 16'd2);
      wr(5'h02, 16'h000A);
      repeat (3) @(negedge clk);
      rd(5'h01, d); check("R9 channel 1 flags on ordinary match", d, 16'h0001);
      rd(5'h02, d); check("R9 mode bit reads back", d, 16'h000A);

      // R10 register access and stopped counters
      wr(5'h02, 16'h0000);
      rd(5'h1C, d); check("R10 stopped counter reads 0", d, 16'h0000);
      wr(5'h15, 16'h1234);
      rd(5'h15, d); check("R10 cycle register readback", d, 16'h1234);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule